// File: doc/BRIEF.md
# Configurable Programmable-Logic Macrocell

This block is one output cell of a programmable logic device. It receives the summed product-term result for its output, the control terms of its logic block, the device-wide clocks, a global tri-state input and the level seen on its own pad. Static configuration inputs choose how the cell behaves. The storage element can be a D register, a T register or bypassed for a combinational output. The register can be clocked from one of two global clocks or one of two control terms, and each global clock can use either polarity. Two control terms can force the register high or low, and the pad driver can be enabled by one of four control terms or be fixed on or off.

The design runs on a single fabric clock `clk`. Every clock source is treated as a level, and the selected source, after the polarity choice, is edge-detected. A detected edge acts as a load enable for one register, so no clock is derived from logic. Preset and reset from the control terms take effect on the next fabric clock edge, independent of the selected source. All four outputs are registered. The cell returns two feedback values: the macrocell value taken before the pad driver, and the value present at the pad, which is the external level whenever the driver is off.

Top module: `mcell_core`

## Requirements
- R1: In D mode (`cfg_mode_i` = 0), an active edge of the selected source loads `sop_i` into the register. The new value appears on `fb_cell_o` two `clk` edges after the edge of `clk` at which the source level first shows the active edge.
- R2: In T mode (`cfg_mode_i` = 1), an active edge inverts the register when `sop_i` is 1 and leaves it unchanged when `sop_i` is 0.
- R3: In combinational mode (`cfg_mode_i[1]` = 1), `pad_o` and `fb_cell_o` equal `sop_i` as sampled one `clk` edge earlier, whatever the clock sources do.
- R4: `cfg_clk_sel_i` picks the register clock: 0 selects `gclk_i[0]`, 1 selects `gclk_i[1]`, 2 selects `ct_i[2]` and 3 selects `ct_i[3]`. Transitions on the sources that are not selected do not change the register.
- R5: With `cfg_clk_fall_i` = 1, a selected global clock is active on its falling transition instead of its rising one. Control-term clocks are always active on the rising transition, whatever `cfg_clk_fall_i` is.
- R6: While `cfg_init_en_i` = 1, `ct_i[1]` = 1 clears the register and `ct_i[0]` = 1 sets it, ahead of any clock edge. The clear wins when both are 1. With `cfg_init_en_i` = 0 both terms have no effect on the register.
- R7: While `rst` is 1, the register and all four outputs are 0.
- R8: `cfg_oe_sel_i` picks the pad enable: 0 is never, 1 is always, 2 to 5 follow `ct_i[2]` to `ct_i[5]`, and 6 and 7 are never. `pad_oe_o` shows the selected value one `clk` edge after it is sampled.
- R9: When `cfg_gts_en_i` = 1 and `gts_n_i` = 0, `pad_oe_o` is 0 on the next `clk` edge, whatever `cfg_oe_sel_i` selects. When `cfg_gts_en_i` = 0, `gts_n_i` has no effect.
- R10: `fb_cell_o` always carries the macrocell value, also driven on `pad_o`. `fb_pad_o` equals `pad_o` when `pad_oe_o` is 1, and otherwise equals `pad_in_i` as sampled one `clk` edge earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock; every register samples on its rising edge |
| rst | input | 1 | Synchronous active-high power-on reset |
| sop_i | input | 1 | Sum-of-products result feeding the cell |
| ct_i | input | N_CT (6) | Control terms of the logic block |
| gclk_i | input | N_GCLK (2) | Device-wide clock levels |
| gts_n_i | input | 1 | Global tri-state request, active low |
| pad_in_i | input | 1 | Level currently present at the pad |
| cfg_mode_i | input | 2 | 0 D register, 1 T register, 2 or 3 combinational |
| cfg_clk_sel_i | input | CK_SEL_W (2) | Clock source select |
| cfg_clk_fall_i | input | 1 | Falling-edge select for global clocks |
| cfg_init_en_i | input | 1 | Enables control-term preset and reset |
| cfg_oe_sel_i | input | OE_SEL_W (3) | Pad enable source select |
| cfg_gts_en_i | input | 1 | Lets `gts_n_i` act on this cell |
| pad_o | output | 1 | Value driven toward the pad |
| pad_oe_o | output | 1 | Pad driver enable |
| fb_cell_o | output | 1 | Feedback taken before the pad driver |
| fb_pad_o | output | 1 | Feedback taken at the pad |

## Verification
The bench uses the default parameters: two global clocks, two control-term clocks starting at term 2, six control terms with preset on term 0 and reset on term 1, and four enable terms starting at term 2. With these values every clock-select code, both polarities on a global clock, and every enable code including the two spare ones can be exercised. The same values also allow the preset-against-reset conflict and the preset-against-clock conflict to be driven from plain control-term levels. The vector table covers pad enable, global tri-state and the two feedback paths in combinational mode. The directed sequence covers the register modes, source isolation and initialisation order.

// File: rtl/mcell_pkg.sv
package mcell_pkg;

  typedef enum logic [1:0] {
    MC_DREG = 2'd0,
    MC_TREG = 2'd1,
    MC_COMB = 2'd2
  } mc_mode_e;

  typedef enum logic [2:0] {
    OE_NEVER  = 3'd0,
    OE_ALWAYS = 3'd1
  } mc_oe_fixed_e;

  function automatic logic mode_is_comb(input logic [1:0] m);
    return m[1];
  endfunction

endpackage

// File: rtl/mcell_clk_sel.sv
module mcell_clk_sel #(
  parameter int N_GCLK  = 2,
  parameter int N_CLKCT = 2,
  localparam int N_SRC  = N_GCLK + N_CLKCT,
  localparam int SEL_W  = $clog2(N_SRC),
  localparam int N_SLOT = 1 << SEL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_GCLK-1:0]  gclk_i,
  input  logic [N_CLKCT-1:0] ctclk_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               fall_i,
  output logic               tick_o
);

  logic [N_SLOT-1:0] slot;
  logic              pol_ok;
  logic              src_now;
  logic              src_q;

  for (genvar k = 0; k < N_SLOT; k++) begin : g_slot
    if (k < N_GCLK) begin : g_glb
      assign slot[k] = gclk_i[k];
    end else if (k < N_SRC) begin : g_ct
      assign slot[k] = ctclk_i[k-N_GCLK];
    end else begin : g_pad
      assign slot[k] = 1'b0;
    end
  end

  // polarity applies to device-wide clocks only
  assign pol_ok  = (int'(sel_i) < N_GCLK);
  assign src_now = slot[sel_i] ^ (fall_i & pol_ok);

  always_ff @(posedge clk) begin
    if (rst) src_q <= 1'b1;
    else     src_q <= src_now;
  end

  assign tick_o = src_now & ~src_q;

endmodule

// File: rtl/mcell_store.sv
module mcell_store
  import mcell_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_i,
  input  logic       sop_i,
  input  logic       tick_i,
  input  logic       init_en_i,
  input  logic       set_i,
  input  logic       clr_i,
  output logic       q_o
);

  logic nxt;

  always_comb begin
    nxt = q_o;
    if (init_en_i && clr_i) begin
      nxt = 1'b0;
    end else if (init_en_i && set_i) begin
      nxt = 1'b1;
    end else if (tick_i) begin
      case (mode_i)
        MC_DREG: nxt = sop_i;
        MC_TREG: nxt = q_o ^ sop_i;
        default: nxt = q_o;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q_o <= 1'b0;
    else     q_o <= nxt;
  end

endmodule

// File: rtl/mcell_oe_sel.sv
module mcell_oe_sel #(
  parameter int N_OE_CT = 4,
  localparam int SEL_W  = $clog2(N_OE_CT + 2),
  localparam int N_CAND = 1 << SEL_W
) (
  input  logic [N_OE_CT-1:0] ct_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               gts_en_i,
  input  logic               gts_n_i,
  output logic               oe_o
);

  logic [N_CAND-1:0] cand;

  for (genvar k = 0; k < N_CAND; k++) begin : g_cand
    if (k == 0) begin : g_off
      assign cand[k] = 1'b0;
    end else if (k == 1) begin : g_on
      assign cand[k] = 1'b1;
    end else if (k - 2 < N_OE_CT) begin : g_ct
      assign cand[k] = ct_i[k-2];
    end else begin : g_spare
      assign cand[k] = 1'b0;
    end
  end

  assign oe_o = cand[sel_i] & ~(gts_en_i & ~gts_n_i);

endmodule

// File: rtl/mcell_core.sv
module mcell_core
  import mcell_pkg::*;
#(
  parameter int N_GCLK     = 2,
  parameter int N_CLKCT    = 2,
  parameter int N_CT       = 6,
  parameter int CLK_CT_LSB = 2,
  parameter int N_OE_CT    = 4,
  parameter int OE_CT_LSB  = 2,
  parameter int PRESET_CT  = 0,
  parameter int RESET_CT   = 1,
  localparam int CK_SEL_W  = $clog2(N_GCLK + N_CLKCT),
  localparam int OE_SEL_W  = $clog2(N_OE_CT + 2)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sop_i,
  input  logic [N_CT-1:0]     ct_i,
  input  logic [N_GCLK-1:0]   gclk_i,
  input  logic                gts_n_i,
  input  logic                pad_in_i,
  input  logic [1:0]          cfg_mode_i,
  input  logic [CK_SEL_W-1:0] cfg_clk_sel_i,
  input  logic                cfg_clk_fall_i,
  input  logic                cfg_init_en_i,
  input  logic [OE_SEL_W-1:0] cfg_oe_sel_i,
  input  logic                cfg_gts_en_i,
  output logic                pad_o,
  output logic                pad_oe_o,
  output logic                fb_cell_o,
  output logic                fb_pad_o
);

  logic tick;
  logic q;
  logic cell_val;
  logic oe_val;

  mcell_clk_sel #(
    .N_GCLK  (N_GCLK),
    .N_CLKCT (N_CLKCT)
  ) u_clk_sel (
    .clk     (clk),
    .rst     (rst),
    .gclk_i  (gclk_i),
    .ctclk_i (ct_i[CLK_CT_LSB +: N_CLKCT]),
    .sel_i   (cfg_clk_sel_i),
    .fall_i  (cfg_clk_fall_i),
    .tick_o  (tick)
  );

  mcell_store u_store (
    .clk       (clk),
    .rst       (rst),
    .mode_i    (cfg_mode_i),
    .sop_i     (sop_i),
    .tick_i    (tick),
    .init_en_i (cfg_init_en_i),
    .set_i     (ct_i[PRESET_CT]),
    .clr_i     (ct_i[RESET_CT]),
    .q_o       (q)
  );

  mcell_oe_sel #(
    .N_OE_CT (N_OE_CT)
  ) u_oe_sel (
    .ct_i     (ct_i[OE_CT_LSB +: N_OE_CT]),
    .sel_i    (cfg_oe_sel_i),
    .gts_en_i (cfg_gts_en_i),
    .gts_n_i  (gts_n_i),
    .oe_o     (oe_val)
  );

  assign cell_val = mode_is_comb(cfg_mode_i) ? sop_i : q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_o     <= 1'b0;
      pad_oe_o  <= 1'b0;
      fb_cell_o <= 1'b0;
      fb_pad_o  <= 1'b0;
    end else begin
      pad_o     <= cell_val;
      pad_oe_o  <= oe_val;
      fb_cell_o <= cell_val;
      fb_pad_o  <= oe_val ? cell_val : pad_in_i;
    end
  end

endmodule

// File: rtl/mcell_core_chk.sv
module mcell_core_chk #(
  parameter int OE_SEL_W = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                sop_i,
  input logic                ct_clr_i,
  input logic                pad_in_i,
  input logic                gts_n_i,
  input logic                comb_i,
  input logic                cfg_init_en_i,
  input logic [OE_SEL_W-1:0] cfg_oe_sel_i,
  input logic                cfg_gts_en_i,
  input logic                pad_o,
  input logic                pad_oe_o,
  input logic                fb_cell_o,
  input logic                fb_pad_o
);

  AST_POR_CLEAR: assert property (@(posedge clk)
    rst |=> (!fb_cell_o && !pad_oe_o && !pad_o && !fb_pad_o)); // R7

  AST_GTS_KILL: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cfg_gts_en_i && !gts_n_i)) |-> !pad_oe_o); // R9

  AST_OE_NEVER: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cfg_oe_sel_i == '0)) |-> !pad_oe_o); // R8

  AST_PADFB_EXT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !pad_oe_o) |-> (fb_pad_o == $past(pad_in_i))); // R10

  AST_PADFB_DRV: assert property (@(posedge clk) disable iff (rst)
    pad_oe_o |-> (fb_pad_o == pad_o)); // R10

  AST_COMB_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(comb_i)) |-> (fb_cell_o == $past(sop_i))); // R3

  AST_CLR_WINS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(!comb_i)
     && $past(cfg_init_en_i && ct_clr_i && !comb_i, 2)) |-> !fb_cell_o); // R6

endmodule

bind mcell_core mcell_core_chk #(
  .OE_SEL_W (OE_SEL_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .sop_i         (sop_i),
  .ct_clr_i      (ct_i[RESET_CT]),
  .pad_in_i      (pad_in_i),
  .gts_n_i       (gts_n_i),
  .comb_i        (cfg_mode_i[1]),
  .cfg_init_en_i (cfg_init_en_i),
  .cfg_oe_sel_i  (cfg_oe_sel_i),
  .cfg_gts_en_i  (cfg_gts_en_i),
  .pad_o         (pad_o),
  .pad_oe_o      (pad_oe_o),
  .fb_cell_o     (fb_cell_o),
  .fb_pad_o      (fb_pad_o)
);

// File: tb/tb_mcell_core.sv
`timescale 1ns/1ps
module tb_mcell_core;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sop_i = 1'b0;
  logic [5:0] ct_i = '0;
  logic [1:0] gclk_i = '0;
  logic       gts_n_i = 1'b1;
  logic       pad_in_i = 1'b0;
  logic [1:0] cfg_mode_i = 2'd0;
  logic [1:0] cfg_clk_sel_i = 2'd0;
  logic       cfg_clk_fall_i = 1'b0;
  logic       cfg_init_en_i = 1'b0;
  logic [2:0] cfg_oe_sel_i = 3'd1;
  logic       cfg_gts_en_i = 1'b0;
  logic       pad_o, pad_oe_o, fb_cell_o, fb_pad_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  mcell_core dut (
    .clk            (clk),
    .rst            (rst),
    .sop_i          (sop_i),
    .ct_i           (ct_i),
    .gclk_i         (gclk_i),
    .gts_n_i        (gts_n_i),
    .pad_in_i       (pad_in_i),
    .cfg_mode_i     (cfg_mode_i),
    .cfg_clk_sel_i  (cfg_clk_sel_i),
    .cfg_clk_fall_i (cfg_clk_fall_i),
    .cfg_init_en_i  (cfg_init_en_i),
    .cfg_oe_sel_i   (cfg_oe_sel_i),
    .cfg_gts_en_i   (cfg_gts_en_i),
    .pad_o          (pad_o),
    .pad_oe_o       (pad_oe_o),
    .fb_cell_o      (fb_cell_o),
    .fb_pad_o       (fb_pad_o)
  );

  // {oe_sel[2:0], gts_en, gts_n, ct[5:0], sop, pad_in, expected_oe}
  localparam logic [13:0] VEC [12] = '{
    {3'd1, 1'b0, 1'b1, 6'b000000, 1'b1, 1'b0, 1'b1},
    {3'd0, 1'b0, 1'b1, 6'b000000, 1'b1, 1'b0, 1'b0},
    {3'd2, 1'b0, 1'b1, 6'b000100, 1'b0, 1'b1, 1'b1},
    {3'd2, 1'b0, 1'b1, 6'b111011, 1'b1, 1'b1, 1'b0},
    {3'd3, 1'b0, 1'b1, 6'b001000, 1'b1, 1'b0, 1'b1},
    {3'd4, 1'b0, 1'b1, 6'b010000, 1'b0, 1'b1, 1'b1},
    {3'd5, 1'b0, 1'b1, 6'b100000, 1'b1, 1'b0, 1'b1},
    {3'd5, 1'b0, 1'b1, 6'b011111, 1'b1, 1'b0, 1'b0},
    {3'd1, 1'b1, 1'b0, 6'b000000, 1'b1, 1'b0, 1'b0},
    {3'd1, 1'b1, 1'b1, 6'b000000, 1'b1, 1'b0, 1'b1},
    {3'd1, 1'b0, 1'b0, 6'b000000, 1'b0, 1'b1, 1'b1},
    {3'd6, 1'b0, 1'b1, 6'b111111, 1'b1, 1'b0, 1'b0}
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // compares {pad_oe, pad_o, fb_cell, fb_pad}
  task automatic chk(input string tag, input logic [3:0] exp);
    logic [3:0] act;
    act = {pad_oe_o, pad_o, fb_cell_o, fb_pad_o};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {oe,pad,fb_cell,fb_pad} actual %b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] drv(input logic v);
    return {1'b1, v, v, v};
  endfunction

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: run did not finish, actual running expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    sop_i = 1'b1;
    step(3);
    chk("R7 outputs cleared during reset", 4'b0000);

    // register mode, CLK0 rising
    sop_i = 1'b0;
    rst   = 1'b0;
    step(2);
    sop_i = 1'b1; step(1);
    gclk_i[0] = 1'b1; step(2);
    chk("R1 D capture of 1 on CLK0 rise", drv(1'b1));
    sop_i = 1'b0; step(1);
    gclk_i[0] = 1'b0; step(2);
    chk("R5 CLK0 fall ignored with rising polarity", drv(1'b1));
    ct_i[2] = 1'b1; step(1); ct_i[2] = 1'b0; step(1);
    ct_i[3] = 1'b1; step(1); ct_i[3] = 1'b0; step(1);
    gclk_i[1] = 1'b1; step(1); gclk_i[1] = 1'b0; step(2);
    chk("R4 unselected sources do not clock", drv(1'b1));
    gclk_i[0] = 1'b1; step(2);
    chk("R1 D capture of 0 on CLK0 rise", drv(1'b0));
    gclk_i[0] = 1'b0; step(1);

    // CLK0 falling polarity
    cfg_clk_fall_i = 1'b1; step(2);
    sop_i = 1'b1; step(1);
    gclk_i[0] = 1'b1; step(2);
    chk("R5 CLK0 rise ignored with falling polarity", drv(1'b0));
    gclk_i[0] = 1'b0; step(2);
    chk("R5 CLK0 fall clocks with falling polarity", drv(1'b1));

    // control-term clock CT2, polarity ignored
    cfg_clk_sel_i = 2'd2; sop_i = 1'b0; step(1);
    ct_i[2] = 1'b1; step(2);
    chk("R4 CT2 rise clocks register", drv(1'b0));
    sop_i = 1'b1; ct_i[2] = 1'b0; step(2);
    chk("R5 CT2 fall ignored despite falling polarity", drv(1'b0));
    ct_i[2] = 1'b1; step(2);
    chk("R4 CT2 rise loads 1", drv(1'b1));

    // T mode on CLK0 rising
    cfg_clk_sel_i = 2'd0; cfg_clk_fall_i = 1'b0; cfg_mode_i = 2'd1; ct_i[2] = 1'b0;
    sop_i = 1'b1; step(1);
    gclk_i[0] = 1'b1; step(2);
    chk("R2 T toggles 1 to 0", drv(1'b0));
    gclk_i[0] = 1'b0; step(1);
    gclk_i[0] = 1'b1; step(2);
    chk("R2 T toggles 0 to 1", drv(1'b1));
    sop_i = 1'b0; gclk_i[0] = 1'b0; step(1);
    gclk_i[0] = 1'b1; step(2);
    chk("R2 T holds with sop 0", drv(1'b1));
    gclk_i[0] = 1'b0; step(1);

    // T mode on CT3
    cfg_clk_sel_i = 2'd3; sop_i = 1'b1; step(1);
    ct_i[3] = 1'b1; step(2);
    chk("R4 CT3 clocks T toggle", drv(1'b0));
    ct_i[3] = 1'b0; step(1);

    // T mode on CLK1 falling
    cfg_clk_sel_i = 2'd1; cfg_clk_fall_i = 1'b1; sop_i = 1'b0; step(2);
    sop_i = 1'b1; gclk_i[1] = 1'b1; step(2);
    chk("R5 CLK1 rise ignored with falling polarity", drv(1'b0));
    gclk_i[1] = 1'b0; step(2);
    chk("R5 CLK1 fall toggles register", drv(1'b1));

    // initialisation terms
    cfg_mode_i = 2'd0; cfg_clk_sel_i = 2'd0; cfg_clk_fall_i = 1'b0; sop_i = 1'b0;
    step(1);
    ct_i[1] = 1'b1; step(2);
    chk("R6 reset term ignored when init disabled", drv(1'b1));
    cfg_init_en_i = 1'b1; step(2);
    chk("R6 reset term clears register", drv(1'b0));
    ct_i[1] = 1'b0; ct_i[0] = 1'b1; step(2);
    chk("R6 preset term sets register", drv(1'b1));
    ct_i[1] = 1'b1; step(2);
    chk("R6 reset wins over preset", drv(1'b0));
    ct_i[1] = 1'b0; ct_i[0] = 1'b0; step(1);
    ct_i[0] = 1'b1; gclk_i[0] = 1'b1; step(2);
    chk("R6 preset beats a capture of 0", drv(1'b1));
    ct_i[0] = 1'b0; gclk_i[0] = 1'b0; step(1);

    // power-on reset mid-run
    rst = 1'b1; step(1);
    chk("R7 reset clears a set register", 4'b0000);
    rst = 1'b0; step(2);
    chk("R7 register stays 0 after reset", drv(1'b0));

    // combinational mode vector table
    cfg_init_en_i = 1'b0; cfg_mode_i = 2'd2;
    for (int i = 0; i < 12; i++) begin
      logic s, p, e;
      cfg_oe_sel_i = VEC[i][13:11];
      cfg_gts_en_i = VEC[i][10];
      gts_n_i      = VEC[i][9];
      ct_i         = VEC[i][8:3];
      sop_i        = VEC[i][2];
      pad_in_i     = VEC[i][1];
      s = VEC[i][2]; p = VEC[i][1]; e = VEC[i][0];
      step(1);
      chk($sformatf("R3 R8 R9 R10 vector %0d", i), {e, s, s, (e ? s : p)});
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule